// File: doc/BRIEF.md
# Interrupt Acknowledge Arbiter and Vector Generator

This block settles which interrupt source answers an acknowledge cycle and turns the outcome into an 8-bit exception vector number and the byte address of that vector in the table. Each of `NSRC` sources raises a request at a 3-bit level and owns a 4-bit contention code held in a small writable bank. When an acknowledge starts, the acknowledged level comes from address bits [3:1]. Only sources that request at exactly that level, and whose code is nonzero, take part.

The participants contend one code bit per cycle, most significant bit first, on a wired-OR line. A participant drops out when it drives 0 on a bit where the line reads 1, so the largest code survives. When contention ends, the survivor's own vector number is registered and presented with a one-cycle `done` pulse. If nobody survives, the autovector input gives a level-derived vector. Otherwise the spurious vector is produced. A bus error anywhere in the cycle forces the spurious vector. Two survivors with the same code raise an error flag.

Top module: `irq_ack_arbiter`

## Requirements
- R1: After reset, the contention code of source `SYS_IDX` (default 0) is 4'b1111 and every other source's code is 4'b0000. A `cfg_we` write stores `cfg_code` into the code of source `cfg_sel`.
- R2: A source takes part only if `src_req` is high, its level field `src_lvl[3i+2:3i]` equals `iack_addr[3:1]` at the accepting edge, and its code is nonzero.
- R3: The participant with the largest code wins. Contention runs one bit per cycle over 4 cycles, and `done` is high during the fifth cycle after the cycle in which `iack_start` was accepted.
- R4: With no participant, no autovector and no bus error, `vec_num` is 8'h18 and `spurious` is 1.
- R5: With no participant and `autovec` high at the accepting edge, `vec_num` is 8'h10 plus the acknowledged level, with `spurious` 0 and `src_hit` 0.
- R6: A participating winner takes precedence over `autovec`, so a periodic-timer source beats an external device at the same level.
- R7: If `bus_err` is high at any edge from the accepting edge through the result edge, `vec_num` is 8'h18, `spurious` is 1 and `src_hit` is 0.
- R8: `vec_addr` equals `vec_num` shifted left by one bit (9 bits wide).
- R9: On a win, `src_hit` is 1, `win_idx` is the winner's index and `vec_num` is that source's `src_vec[8i+7:8i]`. Without a win, `win_idx` is 0.
- R10: When more than one participant holds the winning code, `dup_err` is 1 and the lowest-index one among them wins. Otherwise `dup_err` is 0.
- R11: `iack_start` is ignored while an acknowledge is in progress. It neither alters the result nor produces an extra `done`.
- R12: `done` lasts one cycle. All outputs are 0 after reset, and the result outputs hold their values until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for a contention code |
| cfg_sel | input | $clog2(NSRC) | Source whose code is written |
| cfg_code | input | ARB_W | Code value to write |
| src_req | input | NSRC | Request line per source |
| src_lvl | input | 3*NSRC | Requested level per source |
| src_vec | input | 8*NSRC | Vector number each source supplies |
| iack_start | input | 1 | Starts an acknowledge cycle |
| iack_addr | input | 3 | Acknowledge address bits [3:1], the acknowledged level |
| autovec | input | 1 | Requests a level-derived vector |
| bus_err | input | 1 | Bus error during the acknowledge cycle |
| done | output | 1 | One-cycle result strobe |
| win_idx | output | $clog2(NSRC) | Index of the winning source |
| src_hit | output | 1 | A participating source won |
| vec_num | output | 8 | Exception vector number |
| vec_addr | output | 9 | Byte address of the vector in the table |
| spurious | output | 1 | Spurious vector produced |
| dup_err | output | 1 | Two or more participants shared the winning code |

## Verification
A corrupted survivor mask or a wrong bit pointer shows up as a wrong `win_idx` or `vec_num` at the single `done` cycle. This is visible five cycles after the accepted start and never sooner. A bus-error flag that fails to stick, or a level latched at the wrong edge, shows up as a non-spurious vector when 8'h18 is expected, or the reverse. A state machine that re-arms while busy shows up as an extra `done` within the next six cycles. Random requests with frequent code ties are run against a model that takes the maximum directly rather than serially, so a fault in the bit-serial elimination disagrees with the model on the first case it affects.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
  localparam int LVL_W = 3;
  localparam int VEC_W = 8;
  localparam logic [VEC_W-1:0] SPUR_VEC  = 8'h18;
  localparam logic [VEC_W-1:0] AUTO_BASE = 8'h10;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} ack_st_e;

  function automatic logic [VEC_W:0] vec_to_addr(input logic [VEC_W-1:0] v);
    return {v, 1'b0};
  endfunction

  function automatic logic [VEC_W-1:0] auto_vec(input logic [LVL_W-1:0] lvl);
    return AUTO_BASE + VEC_W'(lvl);
  endfunction
endpackage

// File: rtl/irq_code_bank.sv
module irq_code_bank #(
  parameter int NSRC    = 6,
  parameter int ARB_W   = 4,
  parameter int SYS_IDX = 0,
  parameter int IDX_W   = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [IDX_W-1:0]        sel,
  input  logic [ARB_W-1:0]        wdata,
  output logic [NSRC*ARB_W-1:0]   codes
);
  for (genvar g = 0; g < NSRC; g++) begin : g_code
    localparam logic [ARB_W-1:0] RST_VAL = (g == SYS_IDX) ? {ARB_W{1'b1}} : '0;
    logic [ARB_W-1:0] code_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             code_q <= RST_VAL;
      else if (we && (sel == IDX_W'(g)))      code_q <= wdata;
    end
    assign codes[g*ARB_W +: ARB_W] = code_q;
  end
endmodule

// File: rtl/irq_contend.sv
module irq_contend #(
  parameter int NSRC  = 6,
  parameter int ARB_W = 4,
  localparam int BIT_W = (ARB_W > 1) ? $clog2(ARB_W) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic                  step,
  input  logic [NSRC-1:0]       load_mask,
  input  logic [NSRC*ARB_W-1:0] load_codes,
  output logic [NSRC-1:0]       alive,
  output logic                  last_bit
);
  logic [ARB_W-1:0] snap [NSRC];
  logic [BIT_W-1:0] ptr;
  logic [NSRC-1:0]  cur_bits;
  logic [NSRC-1:0]  drop_mask;
  logic             bus_bit;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    snap[g] <= '0;
      else if (load) snap[g] <= load_codes[g*ARB_W +: ARB_W];
    end
    assign cur_bits[g] = snap[g][ptr];
  end

  // wired-OR line: a 1 from any survivor dominates
  assign bus_bit   = |(alive & cur_bits);
  assign drop_mask = alive & ~cur_bits & {NSRC{bus_bit}};
  assign last_bit  = (ptr == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alive <= '0;
      ptr   <= '0;
    end else if (load) begin
      alive <= load_mask;
      ptr   <= BIT_W'(ARB_W - 1);
    end else if (step) begin
      alive <= alive & ~drop_mask;
      if (!last_bit) ptr <= ptr - 1'b1;
    end
  end
endmodule

// File: rtl/irq_vec_select.sv
module irq_vec_select import irq_ack_pkg::*; #(
  parameter int NSRC  = 6,
  parameter int IDX_W = 3
) (
  input  logic [NSRC-1:0]       alive,
  input  logic [NSRC*VEC_W-1:0] src_vec,
  input  logic                  berr,
  input  logic                  av,
  input  logic [LVL_W-1:0]      lvl,
  output logic [VEC_W-1:0]      vec,
  output logic [IDX_W-1:0]      idx,
  output logic                  hit,
  output logic                  spur,
  output logic                  dup
);
  logic [VEC_W-1:0] vecs [NSRC];
  logic             any;
  logic [IDX_W-1:0] first;

  for (genvar g = 0; g < NSRC; g++) begin : g_unpack
    assign vecs[g] = src_vec[g*VEC_W +: VEC_W];
  end

  always_comb begin
    any   = 1'b0;
    dup   = 1'b0;
    first = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (alive[i]) begin
        if (any) dup = 1'b1;
        else     first = IDX_W'(i);
        any = 1'b1;
      end
    end
  end

  always_comb begin
    vec  = SPUR_VEC;
    idx  = '0;
    hit  = 1'b0;
    spur = 1'b1;
    if (!berr) begin
      if (any) begin
        vec  = vecs[first];
        idx  = first;
        hit  = 1'b1;
        spur = 1'b0;
      end else if (av) begin
        vec  = auto_vec(lvl);
        spur = 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_ack_arbiter.sv
module irq_ack_arbiter import irq_ack_pkg::*; #(
  parameter int NSRC    = 6,
  parameter int ARB_W   = 4,
  parameter int SYS_IDX = 0,
  localparam int IDX_W  = $clog2(NSRC)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [IDX_W-1:0]      cfg_sel,
  input  logic [ARB_W-1:0]      cfg_code,
  input  logic [NSRC-1:0]       src_req,
  input  logic [NSRC*LVL_W-1:0] src_lvl,
  input  logic [NSRC*VEC_W-1:0] src_vec,
  input  logic                  iack_start,
  input  logic [3:1]            iack_addr,
  input  logic                  autovec,
  input  logic                  bus_err,
  output logic                  done,
  output logic [IDX_W-1:0]      win_idx,
  output logic                  src_hit,
  output logic [VEC_W-1:0]      vec_num,
  output logic [VEC_W:0]        vec_addr,
  output logic                  spurious,
  output logic                  dup_err
);
  logic [NSRC*ARB_W-1:0] code_flat;
  ack_st_e               st;
  logic                  start_accept, busy, berr_seen, av_q, last_bit, step_en;
  logic [LVL_W-1:0]      lvl_q;
  logic [NSRC-1:0]       part_mask, surv_mask;
  logic [LVL_W-1:0]      ack_lvl;
  logic [VEC_W-1:0]      sel_vec;
  logic [IDX_W-1:0]      sel_idx;
  logic                  sel_hit, sel_spur, sel_dup, berr_now;

  assign ack_lvl      = iack_addr;
  assign start_accept = (st == ST_IDLE) && iack_start;
  assign busy         = (st != ST_IDLE);
  assign step_en      = (st == ST_RUN);
  assign berr_now     = berr_seen | bus_err;

  irq_code_bank #(.NSRC(NSRC), .ARB_W(ARB_W), .SYS_IDX(SYS_IDX), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_code), .codes(code_flat)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_part
    assign part_mask[g] = src_req[g]
                       && (src_lvl[g*LVL_W +: LVL_W] == ack_lvl)
                       && (code_flat[g*ARB_W +: ARB_W] != '0);
  end

  irq_contend #(.NSRC(NSRC), .ARB_W(ARB_W)) u_contend (
    .clk(clk), .rst_n(rst_n), .load(start_accept), .step(step_en),
    .load_mask(part_mask), .load_codes(code_flat), .alive(surv_mask), .last_bit(last_bit)
  );

  irq_vec_select #(.NSRC(NSRC), .IDX_W(IDX_W)) u_select (
    .alive(surv_mask), .src_vec(src_vec), .berr(berr_now), .av(av_q), .lvl(lvl_q),
    .vec(sel_vec), .idx(sel_idx), .hit(sel_hit), .spur(sel_spur), .dup(sel_dup)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      lvl_q     <= '0;
      av_q      <= 1'b0;
      berr_seen <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (start_accept) begin
          st        <= ST_RUN;
          lvl_q     <= ack_lvl;
          av_q      <= autovec;
          berr_seen <= bus_err;
        end
        ST_RUN: begin
          berr_seen <= berr_now;
          if (last_bit) st <= ST_FIN;
        end
        ST_FIN: begin
          berr_seen <= berr_now;
          st        <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done     <= 1'b0;
      win_idx  <= '0;
      src_hit  <= 1'b0;
      vec_num  <= '0;
      vec_addr <= '0;
      spurious <= 1'b0;
      dup_err  <= 1'b0;
    end else begin
      done <= (st == ST_FIN);
      if (st == ST_FIN) begin
        win_idx  <= sel_idx;
        src_hit  <= sel_hit;
        vec_num  <= sel_vec;
        vec_addr <= vec_to_addr(sel_vec);
        spurious <= sel_spur;
        dup_err  <= sel_dup;
      end
    end
  end
endmodule

// File: rtl/irq_ack_arbiter_chk.sv
module irq_ack_arbiter_chk import irq_ack_pkg::*; #(
  parameter int NSRC  = 6,
  parameter int ARB_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             done,
  input logic             spurious,
  input logic             src_hit,
  input logic [VEC_W-1:0] vec_num,
  input logic             start_accept,
  input logic             busy,
  input logic [NSRC-1:0]  surv_mask,
  input logic             berr_seen
);
  logic [7:0] lat;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            lat <= '0;
    else if (start_accept) lat <= 8'd1;
    else if (done)         lat <= '0;
    else if (lat != '0)    lat <= lat + 8'd1;
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R12
  AST_SPUR_CODE:   assert property (@(posedge clk) disable iff (!rst_n) (done && spurious) |-> (vec_num == SPUR_VEC)); // R4
  AST_HIT_EXCL:    assert property (@(posedge clk) disable iff (!rst_n) (done && src_hit) |-> !spurious); // R6
  AST_BERR_SPUR:   assert property (@(posedge clk) disable iff (!rst_n) (done && berr_seen) |-> (spurious && !src_hit)); // R7
  AST_NO_REJOIN:   assert property (@(posedge clk) disable iff (!rst_n) (busy && $past(busy)) |-> ((surv_mask & ~$past(surv_mask)) == '0)); // R3
  AST_LATENCY:     assert property (@(posedge clk) disable iff (!rst_n) done |-> (lat == 8'(ARB_W + 2))); // R3
endmodule

bind irq_ack_arbiter irq_ack_arbiter_chk #(.NSRC(NSRC), .ARB_W(ARB_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .done(done), .spurious(spurious), .src_hit(src_hit),
  .vec_num(vec_num), .start_accept(start_accept), .busy(busy),
  .surv_mask(surv_mask), .berr_seen(berr_seen)
);

// File: tb/irq_ack_arbiter_tb_top.sv
`timescale 1ns/1ps
module irq_ack_arbiter_tb_top;
  localparam int NSRC = 6;
  localparam int IW   = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic            cfg_we = 0;
  logic [IW-1:0]   cfg_sel = 0;
  logic [3:0]      cfg_code = 0;
  logic [NSRC-1:0] src_req;
  logic [NSRC*3-1:0] src_lvl;
  logic [NSRC*8-1:0] src_vec;
  logic            iack_start = 0, autovec = 0, bus_err = 0;
  logic [3:1]      iack_addr = 0;
  logic            done, src_hit, spurious, dup_err;
  logic [IW-1:0]   win_idx;
  logic [7:0]      vec_num;
  logic [8:0]      vec_addr;

  bit         req_b [NSRC];
  logic [2:0] lvl_b [NSRC];
  logic [3:0] code_m [NSRC];
  logic [7:0] vec_b [NSRC];

  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      src_req[i]       = req_b[i];
      src_lvl[i*3 +: 3] = lvl_b[i];
      src_vec[i*8 +: 8] = vec_b[i];
    end
  end

  irq_ack_arbiter #(.NSRC(NSRC)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_code(cfg_code),
    .src_req(src_req), .src_lvl(src_lvl), .src_vec(src_vec), .iack_start(iack_start),
    .iack_addr(iack_addr), .autovec(autovec), .bus_err(bus_err), .done(done),
    .win_idx(win_idx), .src_hit(src_hit), .vec_num(vec_num), .vec_addr(vec_addr),
    .spurious(spurious), .dup_err(dup_err)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string tag, input string what, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, expv);
    end
  endtask

  typedef struct packed { logic [7:0] vec; logic hit; logic [IW-1:0] idx; logic spur; logic dup; } exp_t;

  // reference: direct maximum over participants, no serial elimination
  function automatic exp_t model(input logic [2:0] lvl, input bit av, input bit be);
    exp_t e; int best = 0; int cnt = 0; int w = 0;
    for (int i = 0; i < NSRC; i++)
      if (req_b[i] && lvl_b[i] == lvl && code_m[i] != 0) begin
        if (int'(code_m[i]) > best) begin best = code_m[i]; cnt = 1; w = i; end
        else if (int'(code_m[i]) == best) cnt++;
      end
    e.dup = (cnt > 1);
    e.hit = 0; e.idx = 0; e.spur = 1; e.vec = 8'h18;
    if (!be) begin
      if (best > 0) begin e.hit = 1; e.idx = IW'(w); e.spur = 0; e.vec = vec_b[w]; end
      else if (av) begin e.spur = 0; e.vec = 8'h10 + 8'(lvl); end
    end
    return e;
  endfunction

  task automatic wr_code(input int s, input logic [3:0] c);
    @(negedge clk); cfg_we = 1; cfg_sel = IW'(s); cfg_code = c;
    @(negedge clk); cfg_we = 0;
    code_m[s] = c;
  endtask

  task automatic do_ack(input string tag, input logic [2:0] lvl, input bit av,
                        input int berr_at, input bit restart);
    exp_t e; bit early = 0; bit extra = 0; logic [7:0] held;
    e = model(lvl, av, berr_at >= 0 && berr_at <= 5);
    @(negedge clk); iack_start = 1; iack_addr = lvl; autovec = av; bus_err = (berr_at == 0);
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      if (done) early = 1;
      iack_start = restart && (k == 2);
      iack_addr  = restart ? ~lvl : lvl;
      autovec    = 0;
      bus_err    = (berr_at == k);
    end
    @(negedge clk); bus_err = 0; iack_start = 0;
    chk("R3", "done timing", {early, done}, 1);
    chk(tag, "vec_num", vec_num, e.vec);
    chk("R8", "vec_addr", vec_addr, int'(e.vec) * 2);
    chk("R9", "src_hit", src_hit, e.hit);
    chk("R9", "win_idx", win_idx, e.idx);
    chk("R4", "spurious", spurious, e.spur);
    chk("R10", "dup_err", dup_err, e.dup);
    held = vec_num;
    @(negedge clk);
    chk("R12", "done one cycle", done, 0);
    chk("R12", "vec held", vec_num, held);
    if (restart) begin
      for (int k = 0; k < 6; k++) begin @(negedge clk); if (done) extra = 1; end
      chk("R11", "no extra done", extra, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got 0 expected 1 completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd715));
    for (int i = 0; i < NSRC; i++) begin
      req_b[i] = 0; lvl_b[i] = 0; vec_b[i] = 8'(8'h40 + i); code_m[i] = (i == 0) ? 4'hF : 4'h0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R12", "reset done", done, 0);
    chk("R12", "reset vec", vec_num, 0);
    chk("R12", "reset spurious", spurious, 0);

    // R1: reset codes, system source wins, others cannot participate
    req_b[0] = 1; lvl_b[0] = 3; req_b[1] = 1; lvl_b[1] = 3;
    do_ack("R1", 3'd3, 0, -1, 0);
    req_b[0] = 0;
    do_ack("R1", 3'd3, 0, -1, 0);
    req_b[1] = 0;

    // R2: level filter
    wr_code(2, 4'd5); wr_code(3, 4'd9);
    req_b[2] = 1; lvl_b[2] = 4; req_b[3] = 1; lvl_b[3] = 2;
    do_ack("R2", 3'd4, 0, -1, 0);
    // R3: largest code wins bit-serially
    wr_code(1, 4'b1010); wr_code(4, 4'b0111); wr_code(5, 4'b1001);
    for (int i = 1; i < NSRC; i++) begin req_b[i] = 1; lvl_b[i] = 6; end
    do_ack("R3", 3'd6, 0, -1, 0);
    // R4 and R5: no participant
    for (int i = 0; i < NSRC; i++) req_b[i] = 0;
    do_ack("R4", 3'd6, 0, -1, 0);
    do_ack("R5", 3'd6, 1, -1, 0);
    do_ack("R5", 3'd1, 1, -1, 0);
    // R6: timer source beats external autovector
    req_b[4] = 1; lvl_b[4] = 5; wr_code(4, 4'd3);
    do_ack("R6", 3'd5, 1, -1, 0);
    // R7: bus error mid-cycle and at the last edge
    do_ack("R7", 3'd5, 0, 3, 0);
    do_ack("R7", 3'd5, 1, 5, 0);
    // R10: tie
    wr_code(2, 4'd7); wr_code(5, 4'd7);
    req_b[2] = 1; lvl_b[2] = 2; req_b[5] = 1; lvl_b[5] = 2;
    do_ack("R10", 3'd2, 0, -1, 0);
    // R11: start while busy
    do_ack("R11", 3'd2, 0, -1, 1);

    for (int n = 0; n < 300; n++) begin
      for (int i = 0; i < NSRC; i++) begin
        req_b[i] = 1'($urandom % 2); lvl_b[i] = 3'($urandom % 8); vec_b[i] = 8'($urandom);
      end
      wr_code(int'($urandom % NSRC), 4'($urandom % 16));
      wr_code(int'($urandom % NSRC), 4'($urandom % 16));
      do_ack("R3", lvl_b[$urandom % NSRC], 1'($urandom % 2),
             ($urandom % 6 == 0) ? int'($urandom % 6) : -1, ($urandom % 10 == 0));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule